// File: doc/BRIEF.md
# Page Buffer Merge Engine

This block is the data path behind the two page-modifying commands of a serial flash device: the command that alters a page byte by byte and the command that can only clear bits. It holds a one-page staging buffer. While a command is open it takes a start column and then a stream of byte strobes, placing each byte at the current column and stepping the column with wrap-around inside the page. When the command closes on a byte boundary with at least one byte received, it starts a self-timed cycle against a simple synchronous page memory.

The cycle first reads the whole stored page and merges it into the buffer. Columns that received a byte take the new value in alter mode, or the AND of old and new in clear-only mode. Columns that received nothing keep the stored value. In alter mode the engine then writes all-ones to every column, holds for an erase interval, and writes the merged buffer back. In clear-only mode it skips the erase and writes the merged buffer directly. A busy flag covers the whole cycle. Command decoding and write protection belong to neighbouring blocks.

Top module: `page_merge_engine`

## Requirements
- R1: After reset, `busy` is 0 and the memory port is idle (`mem_en` = 0). The memory port is never enabled while `busy` is 0.
- R2: Bytes are placed starting at `col_in`. The column advances by one per byte and wraps from the last column (255) back to column 0 of the same page.
- R3: When more than one page of bytes is sent, each column keeps the last byte that was placed in it, so the final 256 bytes are committed.
- R4: A `cs_rise` with `cs_aligned` = 0, or one with no byte received in the command, aborts the command: `busy` stays 0 and the memory is not written.
- R5: In alter mode (`cmd_write` = 1), every loaded column ends up holding exactly its new byte, including bits that go from 0 to 1. Every unloaded column keeps its stored value.
- R6: In alter mode, the engine writes 8'hFF to all 256 columns before any other write, even when only one byte changed. This makes 512 memory writes in total.
- R7: In clear-only mode (`cmd_write` = 0), a loaded column ends up as old AND new, and an unloaded column is unchanged. No erase pass takes place, so exactly 256 memory writes are made.
- R8: `busy` is 1 in the cycle after an accepted close. It stays 1 for at least 512 + ERASE_CYCLES + PROG_CYCLES cycles in alter mode and at least 256 + PROG_CYCLES cycles in clear-only mode, and then returns to 0.
- R9: While `busy` is 1, `cmd_start`, `byte_valid` and `cs_rise` have no effect. No byte is loaded and no second cycle follows.
- R10: A byte strobed in the same cycle as `cs_rise` is loaded, and it counts toward the one-byte minimum.
- R11: The per-column loaded marks are cleared at each `cmd_start`. Bytes from an earlier command are never merged again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_start | input | 1 | Opens a command (accepted only when idle) |
| cmd_write | input | 1 | 1 = alter (merge, erase, program), 0 = clear-only program |
| col_in | input | COL_W | Start column within the page |
| byte_valid | input | 1 | Byte strobe |
| byte_data | input | 8 | Byte value |
| cs_rise | input | 1 | Close strobe (chip select deasserted) |
| cs_aligned | input | 1 | Close fell on a byte boundary |
| mem_en | output | 1 | Page memory access enable |
| mem_we | output | 1 | Page memory write (0 = read) |
| mem_addr | output | COL_W | Page memory column |
| mem_wdata | output | 8 | Page memory write data |
| mem_rdata | input | 8 | Page memory read data, valid one cycle after a read |
| busy | output | 1 | Self-timed cycle in progress |

## Verification
The byte strobe and the close strobe can arrive in the same cycle. That cycle decides both the last buffered column and whether the command is accepted at all. The bench provokes this by sending the only byte of a command together with `cs_rise`, and it passes only if that column holds the new byte and the cycle ran. It also pushes fresh strobes into a running cycle and judges them by the final page image and by `busy` staying low afterwards.

// File: rtl/pm_pkg.sv
package pm_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOAD,
        ST_MERGE,
        ST_ERASE_WR,
        ST_ERASE_WAIT,
        ST_PROG_WR,
        ST_PROG_WAIT
    } pm_state_e;

    // Choose the value a column carries into the program pass.
    function automatic logic [BYTE_W-1:0] merge_byte(
        input logic              alter,
        input logic              loaded,
        input logic [BYTE_W-1:0] old_b,
        input logic [BYTE_W-1:0] new_b
    );
        if (!loaded)    return old_b;
        else if (alter) return new_b;
        else            return old_b & new_b;
    endfunction
endpackage

// File: rtl/pm_page_buffer.sv
module pm_page_buffer #(
    parameter int COL_W = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      clr_flags,
    input  logic                      ld_en,
    input  logic [COL_W-1:0]          ld_col,
    input  logic [pm_pkg::BYTE_W-1:0] ld_data,
    input  logic                      mg_en,
    input  logic [COL_W-1:0]          mg_col,
    input  logic [pm_pkg::BYTE_W-1:0] mg_data,
    input  logic [COL_W-1:0]          rd_col,
    output logic [pm_pkg::BYTE_W-1:0] rd_data,
    output logic                      rd_loaded
);
    localparam int PAGE = 1 << COL_W;

    logic [pm_pkg::BYTE_W-1:0] bytes_q [PAGE];
    logic [PAGE-1:0]           flag_q;

    always_ff @(posedge clk) begin
        if (ld_en)      bytes_q[ld_col] <= ld_data;
        else if (mg_en) bytes_q[mg_col] <= mg_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         flag_q <= '0;
        else if (clr_flags) flag_q <= '0;
        else if (ld_en)     flag_q[ld_col] <= 1'b1;
    end

    assign rd_data   = bytes_q[rd_col];
    assign rd_loaded = flag_q[rd_col];
endmodule

// File: rtl/pm_sequencer.sv
module pm_sequencer
    import pm_pkg::*;
#(
    parameter int COL_W        = 8,
    parameter int ERASE_CYCLES = 1000,
    parameter int PROG_CYCLES  = 200
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_start,
    input  logic              cmd_write,
    input  logic [COL_W-1:0]  col_in,
    input  logic              byte_valid,
    input  logic [BYTE_W-1:0] byte_data,
    input  logic              cs_rise,
    input  logic              cs_aligned,
    output logic              clr_flags,
    output logic              ld_en,
    output logic [COL_W-1:0]  ld_col,
    output logic [BYTE_W-1:0] ld_data,
    output logic              mg_en,
    output logic [COL_W-1:0]  mg_col,
    output logic [BYTE_W-1:0] mg_data,
    output logic [COL_W-1:0]  rd_col,
    input  logic [BYTE_W-1:0] buf_data,
    input  logic              buf_loaded,
    output logic              mem_en,
    output logic              mem_we,
    output logic [COL_W-1:0]  mem_addr,
    output logic [BYTE_W-1:0] mem_wdata,
    input  logic [BYTE_W-1:0] mem_rdata,
    output logic              busy
);
    localparam int WAIT_MAX = (ERASE_CYCLES > PROG_CYCLES) ? ERASE_CYCLES : PROG_CYCLES;
    localparam int CNT_W    = $clog2(WAIT_MAX + 1);
    localparam logic [CNT_W-1:0] ERASE_LAST = CNT_W'(ERASE_CYCLES - 1);
    localparam logic [CNT_W-1:0] PROG_LAST  = CNT_W'(PROG_CYCLES - 1);

    typedef struct packed {
        pm_state_e         st;
        logic [COL_W-1:0]  col;
        logic              alter;
        logic              got;
        logic [COL_W:0]    idx;
        logic              pend;
        logic [COL_W-1:0]  pcol;
        logic [CNT_W-1:0]  wcnt;
    } seq_t;

    seq_t r_q, r_d;

    always_comb begin
        r_d       = r_q;
        clr_flags = 1'b0;
        ld_en     = 1'b0;
        ld_col    = r_q.col;
        ld_data   = byte_data;
        rd_col    = r_q.pcol;
        mg_en     = 1'b0;
        mg_col    = r_q.pcol;
        mg_data   = merge_byte(r_q.alter, buf_loaded, mem_rdata, buf_data);
        mem_en    = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = r_q.idx[COL_W-1:0];
        mem_wdata = '1;
        unique case (r_q.st)
            ST_IDLE: begin
                if (cmd_start) begin
                    clr_flags = 1'b1;
                    r_d.st    = ST_LOAD;
                    r_d.col   = col_in;
                    r_d.alter = cmd_write;
                    r_d.got   = 1'b0;
                end
            end
            ST_LOAD: begin
                if (byte_valid) begin
                    ld_en   = 1'b1;
                    r_d.col = r_q.col + 1'b1;
                    r_d.got = 1'b1;
                end
                if (cs_rise) begin
                    if (cs_aligned && (r_q.got || byte_valid)) begin
                        r_d.st   = ST_MERGE;
                        r_d.idx  = '0;
                        r_d.pend = 1'b0;
                    end else begin
                        r_d.st = ST_IDLE;
                    end
                end
            end
            ST_MERGE: begin
                mem_en   = !r_q.idx[COL_W];
                r_d.pend = !r_q.idx[COL_W];
                r_d.pcol = r_q.idx[COL_W-1:0];
                mg_en    = r_q.pend;
                if (r_q.idx[COL_W]) begin
                    r_d.idx = '0;
                    r_d.st  = r_q.alter ? ST_ERASE_WR : ST_PROG_WR;
                end else begin
                    r_d.idx = r_q.idx + 1'b1;
                end
            end
            ST_ERASE_WR: begin
                mem_en = 1'b1;
                mem_we = 1'b1;
                if (&r_q.idx[COL_W-1:0]) begin
                    r_d.st   = ST_ERASE_WAIT;
                    r_d.wcnt = '0;
                end else begin
                    r_d.idx = r_q.idx + 1'b1;
                end
            end
            ST_ERASE_WAIT: begin
                if (r_q.wcnt == ERASE_LAST) begin
                    r_d.st  = ST_PROG_WR;
                    r_d.idx = '0;
                end else begin
                    r_d.wcnt = r_q.wcnt + 1'b1;
                end
            end
            ST_PROG_WR: begin
                rd_col    = r_q.idx[COL_W-1:0];
                mem_en    = 1'b1;
                mem_we    = 1'b1;
                mem_wdata = buf_data;
                if (&r_q.idx[COL_W-1:0]) begin
                    r_d.st   = ST_PROG_WAIT;
                    r_d.wcnt = '0;
                end else begin
                    r_d.idx = r_q.idx + 1'b1;
                end
            end
            ST_PROG_WAIT: begin
                if (r_q.wcnt == PROG_LAST) r_d.st = ST_IDLE;
                else                       r_d.wcnt = r_q.wcnt + 1'b1;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.st <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy = (r_q.st != ST_IDLE) && (r_q.st != ST_LOAD);

    AST_QUIET_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_en); // R1
    AST_ABORT_STAYS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_LOAD && cs_rise && !cs_aligned) |=> !busy); // R4
    AST_ERASE_ALL_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && mem_we && r_q.st != ST_PROG_WR) |-> (mem_wdata == '1)); // R6
    AST_ERASE_BEFORE_PROGRAM: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_PROG_WR && r_q.idx == '0 && r_q.alter) |-> ($past(r_q.st) == ST_ERASE_WAIT)); // R6
    AST_BUSY_FROM_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(cs_rise && cs_aligned)); // R8
    AST_NO_LOAD_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !(ld_en || clr_flags)); // R9
endmodule

// File: rtl/page_merge_engine.sv
module page_merge_engine #(
    parameter int COL_W        = 8,
    parameter int ERASE_CYCLES = 1000,
    parameter int PROG_CYCLES  = 200
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_start,
    input  logic             cmd_write,
    input  logic [COL_W-1:0] col_in,
    input  logic             byte_valid,
    input  logic [7:0]       byte_data,
    input  logic             cs_rise,
    input  logic             cs_aligned,
    output logic             mem_en,
    output logic             mem_we,
    output logic [COL_W-1:0] mem_addr,
    output logic [7:0]       mem_wdata,
    input  logic [7:0]       mem_rdata,
    output logic             busy
);
    logic             clr_flags, ld_en, mg_en, buf_loaded;
    logic [COL_W-1:0] ld_col, mg_col, rd_col;
    logic [7:0]       ld_data, mg_data, buf_data;

    pm_sequencer #(
        .COL_W(COL_W), .ERASE_CYCLES(ERASE_CYCLES), .PROG_CYCLES(PROG_CYCLES)
    ) u_seq (
        .clk(clk), .rst_n(rst_n),
        .cmd_start(cmd_start), .cmd_write(cmd_write), .col_in(col_in),
        .byte_valid(byte_valid), .byte_data(byte_data),
        .cs_rise(cs_rise), .cs_aligned(cs_aligned),
        .clr_flags(clr_flags), .ld_en(ld_en), .ld_col(ld_col), .ld_data(ld_data),
        .mg_en(mg_en), .mg_col(mg_col), .mg_data(mg_data), .rd_col(rd_col),
        .buf_data(buf_data), .buf_loaded(buf_loaded),
        .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .busy(busy)
    );

    pm_page_buffer #(.COL_W(COL_W)) u_buf (
        .clk(clk), .rst_n(rst_n), .clr_flags(clr_flags),
        .ld_en(ld_en), .ld_col(ld_col), .ld_data(ld_data),
        .mg_en(mg_en), .mg_col(mg_col), .mg_data(mg_data),
        .rd_col(rd_col), .rd_data(buf_data), .rd_loaded(buf_loaded)
    );
endmodule

// File: tb/page_merge_engine_test.sv
module page_merge_engine_test;
    localparam int EC = 20;
    localparam int PC = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_start = 1'b0, cmd_write = 1'b0, byte_valid = 1'b0;
    logic cs_rise = 1'b0, cs_aligned = 1'b0;
    logic [7:0] col_in = '0, byte_data = '0, mem_rdata = '0;
    logic mem_en, mem_we, busy;
    logic [7:0] mem_addr, mem_wdata;

    int n_chk = 0, n_bad = 0;
    int wr_cnt = 0, early_non_ff = 0;
    logic [7:0] mem [256];
    logic [7:0] expv [256];

    always #4 clk = ~clk;

    page_merge_engine #(.COL_W(8), .ERASE_CYCLES(EC), .PROG_CYCLES(PC)) uut (
        .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_write(cmd_write),
        .col_in(col_in), .byte_valid(byte_valid), .byte_data(byte_data),
        .cs_rise(cs_rise), .cs_aligned(cs_aligned), .mem_en(mem_en), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .busy(busy)
    );

    always @(posedge clk) begin
        if (mem_en) begin
            if (mem_we) begin
                if (wr_cnt < 256 && mem_wdata != 8'hFF) early_non_ff = early_non_ff + 1;
                wr_cnt = wr_cnt + 1;
                mem[mem_addr] <= mem_wdata;
            end else begin
                mem_rdata <= mem[mem_addr];
            end
        end
    end

    task automatic check(string req, int act, int exp_val);
        n_chk++;
        if (act != exp_val) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp_val);
        end
    endtask

    task automatic check_ge(string req, int act, int min_val);
        n_chk++;
        if (act < min_val) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected at least %0d", req, act, min_val);
        end
    endtask

    task automatic preload(int seed);
        for (int i = 0; i < 256; i++) begin
            mem[i]  = 8'((i * 37 + seed) ^ 8'h5A);
            expv[i] = mem[i];
        end
        wr_cnt = 0;
        early_non_ff = 0;
    endtask

    task automatic open_cmd(logic wr, logic [7:0] col);
        cmd_start = 1'b1; cmd_write = wr; col_in = col;
        @(negedge clk);
        cmd_start = 1'b0;
    endtask

    task automatic push(logic [7:0] d);
        byte_valid = 1'b1; byte_data = d;
        @(negedge clk);
        byte_valid = 1'b0;
    endtask

    task automatic close_cmd(logic aligned, logic with_byte, logic [7:0] d);
        cs_rise = 1'b1; cs_aligned = aligned;
        byte_valid = with_byte; byte_data = d;
        @(negedge clk);
        cs_rise = 1'b0; byte_valid = 1'b0;
    endtask

    task automatic wait_done(output int cycles);
        cycles = 0;
        while (busy && cycles < 5000) begin
            @(negedge clk);
            cycles++;
        end
        if (busy) check("watchdog", 1, 0);
    endtask

    task automatic compare_page(string req);
        int bad = 0, first = -1;
        for (int i = 0; i < 256; i++)
            if (mem[i] !== expv[i]) begin
                bad++;
                if (first < 0) first = i;
            end
        if (first >= 0)
            $display("  column %0d holds %0h, wanted %0h", first, mem[first], expv[first]);
        check(req, bad, 0);
    endtask

    task automatic t_reset;
        check("R1 busy after reset", int'(busy), 0);
        check("R1 mem_en after reset", int'(mem_en), 0);
    endtask

    task automatic t_alter_wrap;
        int cyc;
        preload(3);
        @(negedge clk);
        open_cmd(1'b1, 8'd250);
        for (int k = 0; k < 10; k++) begin
            push(8'(k * 29 + 7));
            expv[(250 + k) % 256] = 8'(k * 29 + 7);
        end
        close_cmd(1'b1, 1'b0, 8'h00);
        check("R8 busy after close", int'(busy), 1);
        wait_done(cyc);
        compare_page("R2 R5 alter with wrap");
        check("R6 write count", wr_cnt, 512);
        check("R6 erase first", early_non_ff, 0);
        check_ge("R8 alter busy length", cyc, 512 + EC + PC);
        check("R8 busy released", int'(busy), 0);
    endtask

    task automatic t_clear_only;
        int cyc;
        preload(11);
        open_cmd(1'b0, 8'd16);
        for (int k = 0; k < 4; k++) begin
            push(8'hF0 >> k);
            expv[16 + k] = mem[16 + k] & (8'hF0 >> k);
        end
        close_cmd(1'b1, 1'b0, 8'h00);
        wait_done(cyc);
        compare_page("R7 clear-only merge");
        check("R7 write count", wr_cnt, 256);
        check_ge("R8 clear-only busy length", cyc, 256 + PC);
    endtask

    task automatic t_overflow;
        int cyc;
        preload(5);
        open_cmd(1'b1, 8'd0);
        for (int k = 0; k < 300; k++) begin
            push(8'(k * 3 + 1));
            expv[k % 256] = 8'(k * 3 + 1);
        end
        close_cmd(1'b1, 1'b0, 8'h00);
        wait_done(cyc);
        compare_page("R3 last page of bytes kept");
    endtask

    task automatic t_abort;
        preload(9);
        open_cmd(1'b1, 8'd40);
        push(8'h12);
        push(8'h34);
        close_cmd(1'b0, 1'b0, 8'h00);
        check("R4 unaligned close busy", int'(busy), 0);
        repeat (5) @(negedge clk);
        check("R4 unaligned close busy later", int'(busy), 0);
        open_cmd(1'b1, 8'd40);
        close_cmd(1'b1, 1'b0, 8'h00);
        check("R4 empty close busy", int'(busy), 0);
        repeat (5) @(negedge clk);
        check("R4 no writes", wr_cnt, 0);
        compare_page("R4 page untouched");
    endtask

    task automatic t_strobes_while_busy;
        int cyc;
        preload(21);
        open_cmd(1'b0, 8'd32);
        push(8'h0F);
        push(8'h3C);
        expv[32] = mem[32] & 8'h0F;
        expv[33] = mem[33] & 8'h3C;
        close_cmd(1'b1, 1'b0, 8'h00);
        repeat (3) @(negedge clk);
        open_cmd(1'b1, 8'd100);
        push(8'hAA);
        close_cmd(1'b1, 1'b1, 8'h55);
        wait_done(cyc);
        compare_page("R9 strobes ignored while busy");
        repeat (4) @(negedge clk);
        check("R9 no second cycle", int'(busy), 0);
        check("R9 write count", wr_cnt, 256);
    endtask

    task automatic t_same_cycle;
        int cyc;
        preload(33);
        open_cmd(1'b1, 8'd7);
        close_cmd(1'b1, 1'b1, 8'hC3);
        expv[7] = 8'hC3;
        check("R10 close with byte accepted", int'(busy), 1);
        wait_done(cyc);
        compare_page("R10 same-cycle byte");
    endtask

    task automatic t_stale_flags;
        int cyc;
        preload(47);
        open_cmd(1'b0, 8'd0);
        for (int k = 0; k < 4; k++) push(8'hFF);
        close_cmd(1'b1, 1'b0, 8'h00);
        wait_done(cyc);
        wr_cnt = 0;
        open_cmd(1'b1, 8'd100);
        push(8'h66);
        expv[100] = 8'h66;
        close_cmd(1'b1, 1'b0, 8'h00);
        wait_done(cyc);
        compare_page("R11 marks cleared per command");
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_alter_wrap();
        t_clear_only();
        t_overflow();
        t_abort();
        t_strobes_while_busy();
        t_same_cycle();
        t_stale_flags();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule